// File: doc/BRIEF.md
# Rendering Coprocessor Control and Error Registers

This block is the host-facing control plane of a small rendering coprocessor. It keeps the run/stop state of the execution core, the per-cause error enables, the global error-interrupt enable, the page-bound checking enable, the two page-bound limits, the plane mask and the 8-bit raster-op code. Error causes arrive from the core as one-cycle strobes. They are latched into a sticky error word, and they raise an interrupt when both the matching enable and the global enable are set.

The host reaches the block through a plain 32-bit write/read port. A write takes effect at the clock edge. A read is combinational on the address. Host writes into the core's 128-entry register file pass through this block. They are forwarded one cycle later when the core is stopped. When the core is running they are refused, and the refusal is recorded as an illegal register access. The whole register window is also visible a second time with address bit 12 set. In that second window the page-bound limits cannot be written.

Top module: `rcp_ctrl_regs`

## Requirements
- R1: After reset, the control word reads 0 except bit 15, the error word reads 0, both bounds, the plane mask and the raster-op code read 0, and `irq_o` is low.
- R2: The control word at 0x00 stores error enables in bits 5:0, the interrupt enable in bit 7, the bound-check enable in bit 12 and the run bit in bit 14. The lower bound (0x08), the upper bound (0x0C) and the plane mask (0x10) store 32 bits. The raster-op register (0x14) keeps bits 7:0 only, and its upper bits read 0.
- R3: Error bit i (i = 0..5) of the error word at 0x04 is set by strobe bit i and stays set until the host writes 1 to that bit. A strobe in the same cycle as the clear wins.
- R4: `irq_o` is high exactly when control bit 7 is set and some error bit is pending whose enable bit is also set. Bit 7 of the error word reads the same value.
- R5: Control bit 15 mirrors the queue-empty input. Control bit 13 is set by the core-write strobe and cleared by writing 1 to it.
- R6: A host write at 0x100 + 4·n (n = 0..127) while the run bit is clear gives a one-cycle `rf_we_o` in the next cycle, with `rf_idx_o` = n and the written data. Addresses outside that window give no register-file write.
- R7: Such a write while the run bit is set produces no `rf_we_o` and sets error bit 3.
- R8: With address bit 12 set, every register reads as in the base window. Writes there behave as in the base window, except that writes to the two bound registers are ignored.
- R9: The word at 0x28 reads the architecture code in bits 7:0 and the revision in bits 15:8, with the other bits 0.
- R10: A write to 0x30 clears the run bit and all error bits at that edge, including strobes in the same cycle. The other registers keep their values.
- R11: Unmapped, write-only (0x30, register-file window) and misaligned addresses read 0, and misaligned writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 13 | Host byte address; bit 12 selects the alias window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational on the address |
| err_cause_i | input | 6 | One-cycle error cause strobes from the core |
| core_wrote_i | input | 1 | Strobe: the core performed a write |
| iq_empty_i | input | 1 | Instruction queue is empty |
| irq_o | output | 1 | Error interrupt |
| core_run_o | output | 1 | Run bit to the core |
| bound_chk_o | output | 1 | Page-bound checking enable |
| page_lo_o | output | 32 | Lower page bound |
| page_hi_o | output | 32 | Upper page bound |
| plane_mask_o | output | 32 | Plane mask |
| rop_o | output | 8 | Raster-op code |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_idx_o | output | 7 | Register-file index |
| rf_data_o | output | 32 | Register-file write data |

## Verification
The assertions take for granted that the cause and core-write strobes and the host write strobe are synchronous to `clk`, that they hold steady across the sampling edge, and that the host port is idle while reset is held. The stimulus changes every input only on the falling edge. It keeps `host_we` at zero during reset. It raises a cause strobe together with a host write only where the test is about the order of set against clear, or about soft reset against a new error.

// File: rtl/rcp_pkg.sv
// Shared constants and types for the rendering coprocessor control block.
// Assumes word-aligned host addressing; offsets below are word indices.
package rcp_pkg;
    localparam int NUM_CAUSE  = 6;
    localparam int CAUSE_REG  = 3;    // illegal register access cause bit
    // word indices within one window (byte offset >> 2)
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_ERR    = 'h01;
    localparam int OFF_PLO    = 'h02;
    localparam int OFF_PHI    = 'h03;
    localparam int OFF_PMASK  = 'h04;
    localparam int OFF_ROP    = 'h05;
    localparam int OFF_ID     = 'h0A;
    localparam int OFF_SRST   = 'h0C;
    localparam int RF_BASE_W  = 'h40;
    // control word bit positions
    localparam int CB_IE      = 7;
    localparam int CB_PBCHK   = 12;
    localparam int CB_WROTE   = 13;
    localparam int CB_RUN     = 14;
    localparam int CB_IQMT    = 15;
    // error word interrupt-pending bit
    localparam int EB_IRQ     = 7;

    typedef struct packed {
        logic ctrl;
        logic err;
        logic plo;
        logic phi;
        logic pmask;
        logic rop;
        logic id;
        logic srst;
        logic rf;
    } rcp_sel_t;
endpackage

// File: rtl/rcp_addr_decode.sv
// Address decoder: turns a host byte address into one-hot register selects,
// the alias flag and the register-file index.
// Assumes the top address bit selects the alias window; misaligned
// addresses select nothing.
module rcp_addr_decode
    import rcp_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int RF_DEPTH = 128
) (
    input  logic [ADDR_W-1:0]           addr,
    output rcp_sel_t                    sel,
    output logic                        alias_o,
    output logic [$clog2(RF_DEPTH)-1:0] rf_idx
);
    localparam int WI_W  = ADDR_W - 3;
    localparam int IDX_W = $clog2(RF_DEPTH);
    localparam logic [WI_W-1:0] RF_LO = WI_W'(RF_BASE_W);
    localparam logic [WI_W-1:0] RF_HI = WI_W'(RF_BASE_W + RF_DEPTH);

    logic [WI_W-1:0] widx;
    logic [WI_W-1:0] rel;
    logic            aligned;

    assign widx    = addr[ADDR_W-2:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign alias_o = addr[ADDR_W-1];
    assign rel     = widx - RF_LO;
    assign rf_idx  = rel[IDX_W-1:0];

    // Compare the word index against each register's slot.
    always_comb begin
        sel.ctrl  = aligned && (widx == WI_W'(OFF_CTRL));
        sel.err   = aligned && (widx == WI_W'(OFF_ERR));
        sel.plo   = aligned && (widx == WI_W'(OFF_PLO));
        sel.phi   = aligned && (widx == WI_W'(OFF_PHI));
        sel.pmask = aligned && (widx == WI_W'(OFF_PMASK));
        sel.rop   = aligned && (widx == WI_W'(OFF_ROP));
        sel.id    = aligned && (widx == WI_W'(OFF_ID));
        sel.srst  = aligned && (widx == WI_W'(OFF_SRST));
        sel.rf    = aligned && (widx >= RF_LO) && (widx < RF_HI);
    end
endmodule

// File: rtl/rcp_err_unit.sv
// Sticky error latch and interrupt generation.
// Each cause bit is set by its strobe and cleared by a host write-one-to-clear;
// a strobe beats a clear in the same cycle, and soft reset beats both.
// Assumes strobes are synchronous single-cycle pulses.
module rcp_err_unit #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cause_i,
    input  logic [N-1:0] w1c_i,
    input  logic         srst_i,
    input  logic [N-1:0] en_i,
    input  logic         ie_i,
    output logic [N-1:0] err_o,
    output logic         irq_o
);
    logic [N-1:0] err_q;

    // Hold, set and clear the sticky cause bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= '0;
        else if (srst_i) err_q <= '0;
        else             err_q <= (err_q & ~w1c_i) | cause_i;
    end

    // Raise the interrupt for any enabled pending cause.
    assign irq_o = ie_i && |(err_q & en_i);
    assign err_o = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(srst_i) |-> (($past(err_q) & ~$past(w1c_i) & ~err_q) == '0)); // R3
    AST_CAUSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(srst_i) |-> (($past(cause_i) & ~err_q) == '0)); // R3
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ie_i); // R4
    AST_SRST_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(srst_i) |-> (err_q == '0)); // R10
endmodule

// File: rtl/rcp_rf_gate.sv
// Gate for host writes into the core's register file.
// Forwards a request one cycle later only while the core is stopped;
// a request while running is refused and reported through reject_o.
module rcp_rf_gate #(
    parameter int DW = 32,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          run_i,
    input  logic [IW-1:0] idx_i,
    input  logic [DW-1:0] data_i,
    output logic          rf_we_o,
    output logic [IW-1:0] rf_idx_o,
    output logic [DW-1:0] rf_data_o,
    output logic          reject_o
);
    // Flag a refused write as it arrives.
    assign reject_o = req_i && run_i;

    // Register an accepted write toward the register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we_o   <= 1'b0;
            rf_idx_o  <= '0;
            rf_data_o <= '0;
        end else begin
            rf_we_o <= req_i && !run_i;
            if (req_i && !run_i) begin
                rf_idx_o  <= idx_i;
                rf_data_o <= data_i;
            end
        end
    end

    AST_RF_WE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> $past(!run_i)); // R7
    AST_REJECT_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_i && run_i) |-> !rf_we_o); // R7
    AST_RF_WE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> $past(req_i)); // R6
endmodule

// File: rtl/rcp_ctrl_regs.sv
// Control/status register block of a rendering coprocessor.
// Holds run state, enables, bounds, plane mask and raster-op code; latches
// core error causes; gates host register-file writes; serves a base and an
// alias window in which the bounds are read-only.
// Assumes host writes are single-cycle and reads are combinational.
module rcp_ctrl_regs
    import rcp_pkg::*;
#(
    parameter int          ADDR_W   = 13,
    parameter int          DW       = 32,
    parameter int          RF_DEPTH = 128,
    parameter logic [7:0]  ARCH_ID  = 8'h01,
    parameter logic [7:0]  CHIP_REV = 8'h02
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [DW-1:0]               host_wdata,
    output logic [DW-1:0]               host_rdata,
    input  logic [NUM_CAUSE-1:0]        err_cause_i,
    input  logic                        core_wrote_i,
    input  logic                        iq_empty_i,
    output logic                        irq_o,
    output logic                        core_run_o,
    output logic                        bound_chk_o,
    output logic [DW-1:0]               page_lo_o,
    output logic [DW-1:0]               page_hi_o,
    output logic [DW-1:0]               plane_mask_o,
    output logic [7:0]                  rop_o,
    output logic                        rf_we_o,
    output logic [$clog2(RF_DEPTH)-1:0] rf_idx_o,
    output logic [DW-1:0]               rf_data_o
);
    localparam int IDX_W = $clog2(RF_DEPTH);

    rcp_sel_t               sel;
    logic                   in_alias;
    logic [IDX_W-1:0]       dec_idx;
    logic [NUM_CAUSE-1:0]   en_q;
    logic                   ie_q, pbchk_q, run_q, wrote_q;
    logic [NUM_CAUSE-1:0]   err_vec;
    logic [NUM_CAUSE-1:0]   cause_all;
    logic [NUM_CAUSE-1:0]   w1c_mask;
    logic                   srst_wr;
    logic                   rf_req;
    logic                   rf_reject;
    logic                   bound_wr_ok;

    rcp_addr_decode #(.ADDR_W(ADDR_W), .RF_DEPTH(RF_DEPTH)) u_dec (
        .addr    (host_addr),
        .sel     (sel),
        .alias_o (in_alias),
        .rf_idx  (dec_idx)
    );

    assign srst_wr     = host_we && sel.srst;
    assign rf_req      = host_we && sel.rf;
    assign bound_wr_ok = host_we && !in_alias;
    assign w1c_mask    = (host_we && sel.err) ? host_wdata[NUM_CAUSE-1:0] : '0;

    // Fold the refused register-file write into its cause bit.
    always_comb begin
        cause_all = err_cause_i;
        cause_all[CAUSE_REG] = err_cause_i[CAUSE_REG] | rf_reject;
    end

    rcp_err_unit #(.N(NUM_CAUSE)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_all),
        .w1c_i   (w1c_mask),
        .srst_i  (srst_wr),
        .en_i    (en_q),
        .ie_i    (ie_q),
        .err_o   (err_vec),
        .irq_o   (irq_o)
    );

    rcp_rf_gate #(.DW(DW), .IW(IDX_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (rf_req),
        .run_i     (run_q),
        .idx_i     (dec_idx),
        .data_i    (host_wdata),
        .rf_we_o   (rf_we_o),
        .rf_idx_o  (rf_idx_o),
        .rf_data_o (rf_data_o),
        .reject_o  (rf_reject)
    );

    // Control word fields: enables and run bit, soft reset stops the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            ie_q    <= 1'b0;
            pbchk_q <= 1'b0;
            run_q   <= 1'b0;
        end else if (srst_wr) begin
            run_q   <= 1'b0;
        end else if (host_we && sel.ctrl) begin
            en_q    <= host_wdata[NUM_CAUSE-1:0];
            ie_q    <= host_wdata[CB_IE];
            pbchk_q <= host_wdata[CB_PBCHK];
            run_q   <= host_wdata[CB_RUN];
        end
    end

    // Core-write status flag: set by the core, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                                           wrote_q <= 1'b0;
        else if (core_wrote_i)                                wrote_q <= 1'b1;
        else if (host_we && sel.ctrl && host_wdata[CB_WROTE]) wrote_q <= 1'b0;
    end

    // Bounds, writable only from the base window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_lo_o <= '0;
            page_hi_o <= '0;
        end else begin
            if (bound_wr_ok && sel.plo) page_lo_o <= host_wdata;
            if (bound_wr_ok && sel.phi) page_hi_o <= host_wdata;
        end
    end

    // Plane mask and raster-op code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane_mask_o <= '0;
            rop_o        <= '0;
        end else begin
            if (host_we && sel.pmask) plane_mask_o <= host_wdata;
            if (host_we && sel.rop)   rop_o        <= host_wdata[7:0];
        end
    end

    assign core_run_o  = run_q;
    assign bound_chk_o = pbchk_q;

    // Read mux over the selected register.
    always_comb begin
        host_rdata = '0;
        if (sel.ctrl) begin
            host_rdata[NUM_CAUSE-1:0] = en_q;
            host_rdata[CB_IE]         = ie_q;
            host_rdata[CB_PBCHK]      = pbchk_q;
            host_rdata[CB_WROTE]      = wrote_q;
            host_rdata[CB_RUN]        = run_q;
            host_rdata[CB_IQMT]       = iq_empty_i;
        end else if (sel.err) begin
            host_rdata[NUM_CAUSE-1:0] = err_vec;
            host_rdata[EB_IRQ]        = irq_o;
        end else if (sel.plo) begin
            host_rdata = page_lo_o;
        end else if (sel.phi) begin
            host_rdata = page_hi_o;
        end else if (sel.pmask) begin
            host_rdata = plane_mask_o;
        end else if (sel.rop) begin
            host_rdata[7:0] = rop_o;
        end else if (sel.id) begin
            host_rdata[15:0] = {CHIP_REV, ARCH_ID};
        end
    end

    AST_SRST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(srst_wr) |-> !core_run_o); // R10
    AST_ALIAS_BOUND_RO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_we && in_alias && (sel.plo || sel.phi))
        |-> ($stable(page_lo_o) && $stable(page_hi_o))); // R8
    AST_WROTE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(core_wrote_i) |-> wrote_q); // R5
endmodule

// File: tb/rcp_ctrl_regs_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module rcp_ctrl_regs_tb;
    localparam int TCLK = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [12:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [5:0]  err_cause_i = '0;
    logic        core_wrote_i = 1'b0;
    logic        iq_empty_i = 1'b1;
    logic        irq_o, core_run_o, bound_chk_o, rf_we_o;
    logic [31:0] page_lo_o, page_hi_o, plane_mask_o, rf_data_o;
    logic [7:0]  rop_o;
    logic [6:0]  rf_idx_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(TCLK/2) clk = ~clk;

    rcp_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .err_cause_i(err_cause_i), .core_wrote_i(core_wrote_i),
        .iq_empty_i(iq_empty_i), .irq_o(irq_o), .core_run_o(core_run_o),
        .bound_chk_o(bound_chk_o), .page_lo_o(page_lo_o),
        .page_hi_o(page_hi_o), .plane_mask_o(plane_mask_o), .rop_o(rop_o),
        .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic pulse_cause(input logic [5:0] m);
        @(negedge clk);
        err_cause_i = m;
        @(negedge clk);
        err_cause_i = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(13'h000, v); check("R1 ctrl", v, 32'h8000);
        rd(13'h004, v); check("R1 err", v, 32'h0);
        rd(13'h008, v); check("R1 plo", v, 32'h0);
        rd(13'h014, v); check("R1 rop", v, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(13'h000, 32'h0000_10BF);
        rd(13'h000, v); check("R2 ctrl", v, 32'h0000_90BF);
        check("R2 bound_chk", {31'b0, bound_chk_o}, 32'h1);
        wr(13'h008, 32'h1234_5678);
        wr(13'h00C, 32'h9ABC_DEF0);
        wr(13'h010, 32'h00FF_00FF);
        wr(13'h014, 32'hFFFF_FFA5);
        rd(13'h008, v); check("R2 plo", v, 32'h1234_5678);
        rd(13'h00C, v); check("R2 phi", v, 32'h9ABC_DEF0);
        rd(13'h010, v); check("R2 pmask", v, 32'h00FF_00FF);
        rd(13'h014, v); check("R2 rop read", v, 32'h0000_00A5);
        check("R2 rop_o", {24'b0, rop_o}, 32'hA5);
        wr(13'h000, 32'h0);
    endtask

    task automatic t_errors;
        logic [31:0] v;
        pulse_cause(6'b000101);
        rd(13'h004, v); check("R3 set", v, 32'h05);
        wr(13'h004, 32'h01);
        rd(13'h004, v); check("R3 w1c", v, 32'h04);
        @(negedge clk);
        host_we = 1'b1; host_addr = 13'h004; host_wdata = 32'h04; err_cause_i = 6'b000100;
        @(negedge clk);
        host_we = 1'b0; err_cause_i = '0;
        rd(13'h004, v); check("R3 set beats clear", v, 32'h04);
        wr(13'h004, 32'h3F);
        rd(13'h004, v); check("R3 all clear", v, 32'h0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(13'h000, 32'h02);
        pulse_cause(6'b000001);
        check("R4 no ie", {31'b0, irq_o}, 32'h0);
        wr(13'h000, 32'h82);
        check("R4 cause not enabled", {31'b0, irq_o}, 32'h0);
        pulse_cause(6'b000010);
        check("R4 irq", {31'b0, irq_o}, 32'h1);
        rd(13'h004, v); check("R4 err word", v, 32'h83);
        wr(13'h004, 32'h02);
        check("R4 irq drops", {31'b0, irq_o}, 32'h0);
        wr(13'h004, 32'h01);
        wr(13'h000, 32'h0);
    endtask

    task automatic t_status;
        logic [31:0] v;
        iq_empty_i = 1'b0;
        rd(13'h000, v); check("R5 iq busy", v, 32'h0);
        @(negedge clk); core_wrote_i = 1'b1;
        @(negedge clk); core_wrote_i = 1'b0;
        rd(13'h000, v); check("R5 wrote set", v, 32'h2000);
        wr(13'h000, 32'h2000);
        rd(13'h000, v); check("R5 wrote clear", v, 32'h0);
        iq_empty_i = 1'b1;
    endtask

    task automatic t_rf_halted;
        logic [31:0] v;
        wr(13'h114, 32'hCAFE_0005);
        check("R6 we", {31'b0, rf_we_o}, 32'h1);
        check("R6 idx", {25'b0, rf_idx_o}, 32'd5);
        check("R6 data", rf_data_o, 32'hCAFE_0005);
        @(negedge clk);
        check("R6 one cycle", {31'b0, rf_we_o}, 32'h0);
        wr(13'h2FC, 32'h0000_007F);
        check("R6 last idx", {24'b0, rf_we_o, rf_idx_o}, 32'hFF);
        wr(13'h300, 32'h1);
        check("R6 past window", {31'b0, rf_we_o}, 32'h0);
        rd(13'h004, v); check("R6 no error", v, 32'h0);
    endtask

    task automatic t_rf_running;
        logic [31:0] v;
        wr(13'h000, 32'h4000);
        check("R7 running", {31'b0, core_run_o}, 32'h1);
        wr(13'h108, 32'h5555_AAAA);
        check("R7 dropped", {31'b0, rf_we_o}, 32'h0);
        rd(13'h004, v); check("R7 reg error", v, 32'h08);
        wr(13'h004, 32'h08);
    endtask

    task automatic t_softreset;
        logic [31:0] v;
        pulse_cause(6'b110000);
        @(negedge clk);
        host_we = 1'b1; host_addr = 13'h030; host_wdata = 32'h1; err_cause_i = 6'b000001;
        @(negedge clk);
        host_we = 1'b0; err_cause_i = '0;
        rd(13'h004, v); check("R10 errors cleared", v, 32'h0);
        check("R10 stopped", {31'b0, core_run_o}, 32'h0);
        rd(13'h000, v); check("R10 ctrl", v, 32'h8000);
        check("R10 plo kept", page_lo_o, 32'h1234_5678);
    endtask

    task automatic t_alias;
        logic [31:0] v;
        rd(13'h1008, v); check("R8 alias read", v, 32'h1234_5678);
        wr(13'h1008, 32'hDEAD_BEEF);
        check("R8 plo ro", page_lo_o, 32'h1234_5678);
        wr(13'h100C, 32'hDEAD_BEEF);
        check("R8 phi ro", page_hi_o, 32'h9ABC_DEF0);
        wr(13'h1010, 32'h1111_2222);
        check("R8 pmask via alias", plane_mask_o, 32'h1111_2222);
        rd(13'h1014, v); check("R8 rop alias", v, 32'hA5);
    endtask

    task automatic t_id;
        logic [31:0] v;
        rd(13'h028, v);  check("R9 id", v, 32'h0201);
        rd(13'h1028, v); check("R9 id alias", v, 32'h0201);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        rd(13'h040, v); check("R11 hole", v, 32'h0);
        rd(13'h030, v); check("R11 srst reads 0", v, 32'h0);
        rd(13'h100, v); check("R11 rf reads 0", v, 32'h0);
        rd(13'h009, v); check("R11 misaligned read", v, 32'h0);
        wr(13'h011, 32'hFFFF_FFFF);
        check("R11 misaligned write", plane_mask_o, 32'h1111_2222);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_errors();
        t_irq();
        t_status();
        t_rf_halted();
        t_rf_running();
        t_softreset();
        t_alias();
        t_id();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule